// File: doc/BRIEF.md
# In-Order Completion Buffer

This block keeps program order for instructions that run out of order. Every instruction that dispatch hands over takes one slot in a 16-slot ring. The block returns the slot number as a tag, and the instruction keeps that tag until it completes. Up to two instructions can be dispatched per cycle. Each one carries a flag that marks it as a store and a flag that marks it as a branch. Execution units report back by tag when an instruction has finished. Each report says whether a branch was taken and whether the instruction faulted.

Each cycle the block looks at the four oldest slots and retires the longest in-order run of finished instructions, up to four. The run ends early in three cases: just before a store that is not in the oldest position, just after a taken branch, and just before a faulting slot. A faulting instruction that reaches the oldest position raises a precise exception with its tag. Nothing retires in that cycle, and every slot is emptied so that dispatch starts again from that tag. Retirement does not wait for results: a slot that has been reported finished without a fault is eligible.

Top module: `cbuf_complete`

## Requirements
- R1: After reset the buffer is empty: `ret_valid` is 0, `exc_valid` is 0, `disp_ready` is 1 for a one-instruction request, and the first tag handed out is 0.
- R2: Accepted dispatch lanes receive consecutive tags modulo 16. Lane 0 gets the next free tag and lane 1 gets that tag plus one. `disp_valid` is used only as 00, 01 or 11.
- R3: `disp_ready` is 1 exactly when the number of free slots is at least the number of requesting lanes and no exception is being raised. A buffer holding 16 instructions never accepts another.
- R4: Retirement is strictly in order. A slot that is not yet finished blocks every younger slot, even slots that have already finished.
- R5: Up to four slots retire per cycle. `ret_valid` is a contiguous prefix starting at bit 0, and lane i reports the tag of the oldest slot plus i (modulo 16).
- R6: A store may retire only in lane 0. A finished store in a younger position ends the group before it.
- R7: A branch that was reported taken retires, and nothing younger retires in the same cycle. A branch that was not taken does not end the group.
- R8: A faulting slot in a younger position ends the group before it. When the faulting slot is the oldest, `exc_valid` is 1, `exc_tag` is its tag, `ret_valid` is 0, and on the next cycle the buffer is empty, with the next dispatched tag equal to the faulting tag.
- R9: A finish report for a tag that holds no instruction has no effect. An instruction dispatched later into that slot stays unfinished.
- R10: A finish report accepted at one clock edge makes the slot eligible for retirement in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 2 | Dispatch request per lane, contiguous from lane 0 |
| disp_store | input | 2 | Lane instruction is a store |
| disp_branch | input | 2 | Lane instruction is a branch |
| disp_ready | output | 1 | All requesting lanes are accepted this cycle |
| disp_tag | output | 8 | Tag for each lane, 4 bits per lane, lane 0 in the low bits |
| fin_valid | input | 1 | Finish report present |
| fin_tag | input | 4 | Tag of the finished instruction |
| fin_taken | input | 1 | Finished branch was taken |
| fin_exc | input | 1 | Finished instruction faulted |
| ret_valid | output | 4 | Retiring lanes this cycle, contiguous from lane 0 |
| ret_tag | output | 16 | Tag per retire lane, 4 bits per lane, lane 0 in the low bits |
| exc_valid | output | 1 | Precise exception from the oldest slot |
| exc_tag | output | 4 | Tag of the faulting instruction |

## Verification
The checker assumes that dispatch requests are contiguous from lane 0 and that the occupancy count moves only by the accepted dispatches minus the retirements, except in a flush cycle. For finish reports it assumes that each instruction is reported at most once. The bench drives only the patterns 00, 01 and 11 on `disp_valid` and reports each live tag exactly once. The one exception is a deliberate stray report sent to an empty slot. The bench also holds every request low during reset.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    localparam int CB_DEPTH  = 16;
    localparam int CB_DISP_W = 2;
    localparam int CB_RET_W  = 4;

    typedef struct packed {
        logic busy;     // slot holds a live instruction
        logic done;     // execution reported finished
        logic store;    // store class
        logic branch;   // branch class
        logic taken;    // branch resolved taken
        logic fault;    // exception recorded
    } cb_entry_t;

    function automatic cb_entry_t cb_new_entry(input logic is_store, input logic is_branch);
        cb_entry_t e;
        e        = '0;
        e.busy   = 1'b1;
        e.store  = is_store;
        e.branch = is_branch;
        return e;
    endfunction

endpackage

// File: rtl/cbuf_alloc.sv
module cbuf_alloc #(
    parameter int DEPTH  = 16,
    parameter int DISP_W = 2,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DISP_W-1:0] disp_valid,
    input  logic              flush,
    input  logic [PTR_W-1:0]  head_ptr,
    output logic [PTR_W-1:0]  tail_ptr,
    output logic [PTR_W-1:0]  occ,
    output logic              disp_ready,
    output logic              disp_accept
);

    logic [PTR_W:0] free_cnt;
    logic [PTR_W:0] req_cnt;

    always_comb begin
        req_cnt = '0;
        for (int i = 0; i < DISP_W; i++) begin
            req_cnt = req_cnt + {{PTR_W{1'b0}}, disp_valid[i]};
        end
    end

    assign occ         = tail_ptr - head_ptr;
    assign free_cnt    = (PTR_W+1)'(DEPTH) - {1'b0, occ};
    assign disp_ready  = !flush && (free_cnt >= req_cnt);
    assign disp_accept = disp_ready && (req_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_ptr <= '0;
        end else if (flush) begin
            tail_ptr <= head_ptr;
        end else if (disp_accept) begin
            tail_ptr <= tail_ptr + req_cnt[PTR_W-1:0];
        end
    end

endmodule

// File: rtl/cbuf_retire_sel.sv
module cbuf_retire_sel
    import cbuf_pkg::*;
#(
    parameter int RET_W = 4
) (
    input  cb_entry_t        win [RET_W],
    output logic [RET_W-1:0] ret_mask,
    output logic             head_fault
);

    logic go;

    always_comb begin
        go = 1'b1;
        for (int i = 0; i < RET_W; i++) begin
            ret_mask[i] = go && win[i].busy && win[i].done && !win[i].fault
                          && ((i == 0) || !win[i].store);
            go = ret_mask[i] && !(win[i].branch && win[i].taken);
        end
        head_fault = win[0].busy && win[0].done && win[0].fault;
    end

endmodule

// File: rtl/cbuf_complete.sv
module cbuf_complete
    import cbuf_pkg::*;
#(
    parameter int DEPTH  = CB_DEPTH,
    parameter int DISP_W = CB_DISP_W,
    parameter int RET_W  = CB_RET_W,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int PTR_W = TAG_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DISP_W-1:0]       disp_valid,
    input  logic [DISP_W-1:0]       disp_store,
    input  logic [DISP_W-1:0]       disp_branch,
    output logic                    disp_ready,
    output logic [DISP_W*TAG_W-1:0] disp_tag,
    input  logic                    fin_valid,
    input  logic [TAG_W-1:0]        fin_tag,
    input  logic                    fin_taken,
    input  logic                    fin_exc,
    output logic [RET_W-1:0]        ret_valid,
    output logic [RET_W*TAG_W-1:0]  ret_tag,
    output logic                    exc_valid,
    output logic [TAG_W-1:0]        exc_tag
);

    cb_entry_t        ent_q [DEPTH];
    cb_entry_t        win   [RET_W];
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_ptr;
    logic [PTR_W-1:0] occ;
    logic             disp_accept;
    logic [RET_W-1:0] ret_mask;
    logic             head_fault;
    logic [PTR_W-1:0] n_ret;
    logic [TAG_W-1:0] head_tag;
    logic [TAG_W-1:0] tail_tag;

    assign head_tag = head_q[TAG_W-1:0];
    assign tail_tag = tail_ptr[TAG_W-1:0];

    cbuf_alloc #(.DEPTH(DEPTH), .DISP_W(DISP_W)) u_alloc (
        .clk         (clk),
        .rst         (rst),
        .disp_valid  (disp_valid),
        .flush       (head_fault),
        .head_ptr    (head_q),
        .tail_ptr    (tail_ptr),
        .occ         (occ),
        .disp_ready  (disp_ready),
        .disp_accept (disp_accept)
    );

    always_comb begin
        for (int i = 0; i < RET_W; i++) begin
            win[i] = ent_q[head_tag + TAG_W'(i)];
        end
    end

    cbuf_retire_sel #(.RET_W(RET_W)) u_sel (
        .win        (win),
        .ret_mask   (ret_mask),
        .head_fault (head_fault)
    );

    always_comb begin
        n_ret = '0;
        for (int i = 0; i < RET_W; i++) begin
            n_ret = n_ret + {{(PTR_W-1){1'b0}}, ret_mask[i]};
        end
    end

    generate
        for (genvar g = 0; g < DISP_W; g++) begin : g_dtag
            assign disp_tag[g*TAG_W +: TAG_W] = tail_tag + TAG_W'(g);
        end
        for (genvar g = 0; g < RET_W; g++) begin : g_rtag
            assign ret_tag[g*TAG_W +: TAG_W] = head_tag + TAG_W'(g);
        end
    endgenerate

    assign ret_valid = ret_mask;
    assign exc_valid = head_fault;
    assign exc_tag   = head_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < RET_W; i++) begin
                if (ret_mask[i]) begin
                    ent_q[head_tag + TAG_W'(i)].busy <= 1'b0;
                end
            end
            head_q <= head_q + n_ret;
            if (fin_valid && ent_q[fin_tag].busy) begin
                ent_q[fin_tag].done  <= 1'b1;
                ent_q[fin_tag].taken <= fin_taken;
                ent_q[fin_tag].fault <= fin_exc;
            end
            for (int i = 0; i < DISP_W; i++) begin
                if (disp_accept && disp_valid[i]) begin
                    ent_q[tail_tag + TAG_W'(i)] <= cb_new_entry(disp_store[i], disp_branch[i]);
                end
            end
            if (head_fault) begin
                for (int i = 0; i < DEPTH; i++) begin
                    ent_q[i].busy <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/cbuf_complete_chk.sv
module cbuf_complete_chk #(
    parameter int DEPTH  = 16,
    parameter int DISP_W = 2,
    parameter int RET_W  = 4,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [DISP_W-1:0] disp_valid,
    input logic              disp_ready,
    input logic [RET_W-1:0]  ret_valid,
    input logic              exc_valid,
    input logic [PTR_W-1:0]  occ
);

    logic [PTR_W-1:0] n_acc;
    logic [PTR_W-1:0] n_ret;

    always_comb begin
        n_acc = '0;
        n_ret = '0;
        for (int i = 0; i < DISP_W; i++) begin
            n_acc = n_acc + {{(PTR_W-1){1'b0}}, disp_valid[i] & disp_ready};
        end
        for (int i = 0; i < RET_W; i++) begin
            n_ret = n_ret + {{(PTR_W-1){1'b0}}, ret_valid[i]};
        end
    end

    // R2
    disp_contig_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid & DISP_W'(disp_valid + 1'b1)) == '0);

    // R3
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= PTR_W'(DEPTH));

    // R3
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == PTR_W'(DEPTH) && disp_valid != '0) |-> !disp_ready);

    // R3
    occ_track_chk: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |=> occ == PTR_W'($past(occ) + $past(n_acc) - $past(n_ret)));

    // R5
    ret_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_valid & RET_W'(ret_valid + 1'b1)) == '0);

    // R8
    exc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> ret_valid == '0);

    // R8
    exc_flush_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> occ == '0);

endmodule

bind cbuf_complete cbuf_complete_chk #(.DEPTH(DEPTH), .DISP_W(DISP_W), .RET_W(RET_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .ret_valid  (ret_valid),
    .exc_valid  (exc_valid),
    .occ        (occ)
);

// File: tb/test_cbuf_complete.sv
`timescale 1ns/1ps
module test_cbuf_complete;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  disp_valid = '0;
    logic [1:0]  disp_store = '0;
    logic [1:0]  disp_branch = '0;
    logic        disp_ready;
    logic [7:0]  disp_tag;
    logic        fin_valid = 1'b0;
    logic [3:0]  fin_tag = '0;
    logic        fin_taken = 1'b0;
    logic        fin_exc = 1'b0;
    logic [3:0]  ret_valid;
    logic [15:0] ret_tag;
    logic        exc_valid;
    logic [3:0]  exc_tag;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cbuf_complete i_cbuf_complete (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_store(disp_store), .disp_branch(disp_branch),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_taken(fin_taken), .fin_exc(fin_exc),
        .ret_valid(ret_valid), .ret_tag(ret_tag),
        .exc_valid(exc_valid), .exc_tag(exc_tag)
    );

    typedef struct packed {
        logic [1:0] dv;
        logic [1:0] st;
        logic [1:0] br;
        logic       fv;
        logic [3:0] ft;
        logic       fk;
        logic       fe;
        logic [3:0] eret;
        logic       eexc;
        logic       erdy;
        logic [3:0] ehead;
    } row_t;

    localparam int NROW = 34;
    localparam row_t TBL [NROW] = '{
        '{2'b11, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},  // R2 tags 0,1
        '{2'b11, 2'b01, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},  // tag2 store
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd1,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},  // R4 head blocks
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd2,  1'b0, 1'b0, 4'b0011, 1'b0, 1'b1, 4'd0},  // R10
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd3,  1'b0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd2},  // R6 store lane0
        '{2'b11, 2'b00, 2'b01, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd3},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd5,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd4,  1'b1, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b11, 2'b10, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd4},  // R7 taken stop
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd7,  1'b0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd5},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd6,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd6},  // R6 store stop
        '{2'b00, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd7},
        '{2'b11, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b11, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd9,  1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd8,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd10, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd8},  // R8 fault stop
        '{2'b00, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0000, 1'b1, 1'b0, 4'd9},  // R8 exception
        '{2'b11, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},  // R8 restart at 9
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd9,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd10, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd9},
        '{2'b00, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd10},
        '{2'b11, 2'b00, 2'b10, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b11, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b11, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},  // R2 wrap 15,0
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd15, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd14, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd13, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd12, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd11, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd0},
        '{2'b00, 2'b00, 2'b00, 1'b1, 4'd0,  1'b0, 1'b0, 4'b1111, 1'b0, 1'b1, 4'd11}, // R5 R7 four wide
        '{2'b00, 2'b00, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 4'b0011, 1'b0, 1'b1, 4'd15}  // R5 wrap
    };

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        disp_valid = '0; disp_store = '0; disp_branch = '0;
        fin_valid = 1'b0; fin_tag = '0; fin_taken = 1'b0; fin_exc = 1'b0;
    endtask

    task automatic reset_check(input string req);
        disp_valid = 2'b01;
        #1;
        chk(ret_valid == 4'd0, req, "ret_valid", int'(ret_valid), 0);
        chk(exc_valid == 1'b0, req, "exc_valid", int'(exc_valid), 0);
        chk(disp_ready == 1'b1, req, "disp_ready", int'(disp_ready), 1);
        chk(disp_tag[3:0] == 4'd0, req, "first tag", int'(disp_tag[3:0]), 0);
        disp_valid = '0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] exp_tail;
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        reset_check("R1");
        exp_tail = 4'd0;

        for (int r = 0; r < NROW; r++) begin
            row_t v;
            v = TBL[r];
            @(negedge clk);
            chk(ret_valid == v.eret, "R4/R5/R6/R7", $sformatf("row %0d ret_valid", r), int'(ret_valid), int'(v.eret));
            chk(exc_valid == v.eexc, "R8", $sformatf("row %0d exc_valid", r), int'(exc_valid), int'(v.eexc));
            if (v.eexc) begin
                chk(exc_tag == v.ehead, "R8", $sformatf("row %0d exc_tag", r), int'(exc_tag), int'(v.ehead));
            end
            for (int l = 0; l < 4; l++) begin
                if (v.eret[l]) begin
                    chk(ret_tag[l*4 +: 4] == v.ehead + 4'(l), "R5",
                        $sformatf("row %0d lane %0d tag", r, l),
                        int'(ret_tag[l*4 +: 4]), int'(v.ehead + 4'(l)));
                end
            end
            disp_valid = v.dv; disp_store = v.st; disp_branch = v.br;
            fin_valid = v.fv; fin_tag = v.ft; fin_taken = v.fk; fin_exc = v.fe;
            #1;
            chk(disp_ready == v.erdy, "R3", $sformatf("row %0d disp_ready", r), int'(disp_ready), int'(v.erdy));
            if (v.dv != 2'b00) begin
                chk(disp_tag[3:0] == exp_tail, "R2", $sformatf("row %0d lane0 tag", r), int'(disp_tag[3:0]), int'(exp_tail));
                chk(disp_tag[7:4] == exp_tail + 4'd1, "R2", $sformatf("row %0d lane1 tag", r), int'(disp_tag[7:4]), int'(exp_tail + 4'd1));
            end
            if (v.eexc) exp_tail = v.ehead;
            else if (v.erdy) exp_tail = exp_tail + 4'(v.dv[0]) + 4'(v.dv[1]);
            @(posedge clk);
        end

        // R9: stray finish to empty slot 1 (head = tail = 1 now)
        @(negedge clk);
        idle();
        fin_valid = 1'b1; fin_tag = 4'd1; fin_exc = 1'b1;
        @(posedge clk);
        @(negedge clk);
        idle();
        disp_valid = 2'b01;
        #1;
        chk(disp_tag[3:0] == 4'd1, "R2", "tag after wrap", int'(disp_tag[3:0]), 1);
        @(posedge clk);
        @(negedge clk);
        idle();
        chk(ret_valid == 4'd0, "R9", "stray finish ret", int'(ret_valid), 0);
        chk(exc_valid == 1'b0, "R9", "stray finish exc", int'(exc_valid), 0);
        @(posedge clk);
        @(negedge clk);
        chk(ret_valid == 4'd0, "R9", "still unfinished", int'(ret_valid), 0);
        fin_valid = 1'b1; fin_tag = 4'd1;
        @(posedge clk);
        @(negedge clk);
        idle();
        // R10: eligible the cycle after the report
        chk(ret_valid == 4'b0001, "R10", "retire after finish", int'(ret_valid), 1);
        chk(ret_tag[3:0] == 4'd1, "R10", "retire tag", int'(ret_tag[3:0]), 1);
        @(posedge clk);

        // R3: fill to 15, then to 16
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            disp_valid = 2'b11;
            @(posedge clk);
        end
        @(negedge clk);
        disp_valid = 2'b01;
        @(posedge clk);
        @(negedge clk);
        disp_valid = 2'b11;
        #1;
        chk(disp_ready == 1'b0, "R3", "one free, two asked", int'(disp_ready), 0);
        disp_valid = 2'b01;
        #1;
        chk(disp_ready == 1'b1, "R3", "one free, one asked", int'(disp_ready), 1);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(disp_ready == 1'b0, "R3", "full buffer", int'(disp_ready), 0);
        disp_valid = '0;
        chk(ret_valid == 4'd0, "R4", "nothing finished", int'(ret_valid), 0);

        // R1: reset from a full buffer
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        reset_check("R1");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule